// File: doc/BRIEF.md
# Packed Lane Shifter with Signed Per-Lane Amounts

The block shifts every element of a 128-bit value vector by an amount taken from the matching element of a 128-bit amount vector. The amount is a signed byte. When it is zero or positive, the lane moves toward its most-significant end. When it is negative, the lane moves toward its least-significant end by the magnitude of the amount. A two-bit size code splits the vector into 8-, 16-, 32- or 64-bit lanes. A mode bit chooses whether right moves fill with zeros or with copies of the lane's top bit.

An amount outside the lane's range does not wrap. It saturates to a defined result: zero for left moves and for zero-fill right moves, and a lane made entirely of the top bit for sign-fill right moves. A width bit marks whether the full 128 bits are active or only the lower 64. When only the lower half is active, the upper half of the result is cleared. The datapath is combinational. One output register stage, qualified by an input strobe, holds the result. The block has no control state beyond that register.

Top module: `vshl_unit`

## Requirements
- R1: For each lane, only its least-significant byte is used as the amount, read as two's complement (-128..127). All higher bits of the lane in the amount vector have no effect on the result.
- R2: An amount of zero or more moves the lane left by that amount and fills with zeros. A negative amount moves the lane right by its magnitude.
- R3: A left move by an amount at or above the lane width gives an all-zero lane, whatever the mode bit.
- R4: With `sign_fill`=0, right moves fill with zeros. A right move whose magnitude is at or above the lane width gives an all-zero lane.
- R5: With `sign_fill`=1, right moves replicate the lane's top bit. A magnitude at or above the lane width acts as a move by width-1, so every bit of the lane equals the original top bit.
- R6: `lane_sz` encodes the lane width as 0=8, 1=16, 2=32 and 3=64 bits. Lane 0 sits in the least-significant bits of every operand, and lanes do not affect each other.
- R7: When `full_width`=0, bits 127:64 of the registered result are zero.
- R8: `out_valid` equals `in_valid` delayed by one clock. The result of inputs presented with `in_valid`=1 appears on `result` after that same edge.
- R9: While `in_valid`=0, `result` keeps its previous value, whatever the other inputs do.
- R10: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| value | input | 128 | Vector whose lanes are shifted |
| amount | input | 128 | Per-lane shift amounts; only the low byte of each lane is used |
| lane_sz | input | 2 | Lane width code (0=8, 1=16, 2=32, 3=64) |
| sign_fill | input | 1 | 1 = arithmetic right moves, 0 = logical |
| full_width | input | 1 | 1 = all 128 bits active, 0 = low 64 bits only |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered shifted vector |

## Verification
The hardest case to reach is a lane wider than a byte whose amount byte is negative and saturating (for example -128) while the rest of that lane in the amount vector holds unrelated bits. A decode that reads the wrong bits as the sign, or compares the whole lane against the width, then goes wrong in exactly this case. The stimulus fills every non-amount byte of the amount vector with a nonzero pattern. It then sweeps, for each lane width and mode, the amounts 0, width-1, width, 127, -1, -(width-1), -width and -128. Each result is compared against an independently written model.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;
    localparam int N_SIZES = 4;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/vshl_elem.sv
module vshl_elem #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [7:0]   amt,
    input  logic         arith,
    output logic [W-1:0] res
);
    localparam int         SHW    = $clog2(W);
    localparam logic [8:0] WIDTH9 = 9'(W);

    logic [8:0]     mag;
    logic           left_ovf;
    logic           right_ovf;
    logic [SHW-1:0] rsh;

    // magnitude of a negative amount; -128 becomes 128
    assign mag       = 9'd0 - {amt[7], amt};
    assign left_ovf  = ({1'b0, amt} >= WIDTH9);
    assign right_ovf = (mag >= WIDTH9);
    assign rsh       = right_ovf ? SHW'(W - 1) : mag[SHW-1:0];

    always_comb begin
        if (!amt[7]) begin
            res = left_ovf ? '0 : (val << amt[SHW-1:0]);
        end else if (arith) begin
            res = W'($signed(val) >>> rsh);
        end else begin
            res = right_ovf ? '0 : (val >> rsh);
        end
    end

    always_comb begin
        if (amt[7] && right_ovf && arith) begin
            // R5
            sign_sat_chk: assert (res == {W{val[W-1]}});
        end
        if (amt[7] && right_ovf && !arith) begin
            // R4
            zero_sat_chk: assert (res == '0);
        end
        if (!amt[7] && left_ovf) begin
            // R3
            left_sat_chk: assert (res == '0);
        end
    end
endmodule

// File: rtl/vshl_bank.sv
module vshl_bank #(
    parameter int VW = 128,
    parameter int W  = 8
) (
    input  logic [VW-1:0] val,
    input  logic [VW-1:0] amt,
    input  logic          arith,
    output logic [VW-1:0] res
);
    localparam int N_LANES = VW / W;

    for (genvar gl = 0; gl < N_LANES; gl++) begin : g_lane
        vshl_elem #(.W(W)) u_elem (
            .val  (val[gl*W +: W]),
            .amt  (amt[gl*W +: 8]),
            .arith(arith),
            .res  (res[gl*W +: W])
        );
    end
endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
    import vshl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] value,
    input  logic [VEC_W-1:0] amount,
    input  logic [1:0]       lane_sz,
    input  logic             sign_fill,
    input  logic             full_width,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    logic [VEC_W-1:0] by_size [N_SIZES];
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] masked;

    for (genvar gs = 0; gs < N_SIZES; gs++) begin : g_size
        vshl_bank #(.VW(VEC_W), .W(8 << gs)) u_bank (
            .val  (value),
            .amt  (amount),
            .arith(sign_fill),
            .res  (by_size[gs])
        );
    end

    always_comb begin
        unique case (lane_sz_e'(lane_sz))
            LANE_8:  picked = by_size[0];
            LANE_16: picked = by_size[1];
            LANE_32: picked = by_size[2];
            LANE_64: picked = by_size[3];
            default: picked = '0;
        endcase
        masked = picked;
        if (!full_width) begin
            masked[VEC_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= masked;
            end
        end
    end

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !full_width |=> result[VEC_W-1:HALF_W] == '0);

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
endmodule

// File: tb/tb_vshl_unit.sv
module tb_vshl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;

    // table: value, amount, size code, sign mode, full width, expected
    localparam logic [127:0] T_VAL [N_VEC] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h279C_D308_8000_0000},
        {64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
        {64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
        {8{16'h8001}},
        {4{32'h0F0F_0F0F}},
        {16{8'h90}}
    };
    localparam logic [127:0] T_AMT [N_VEC] = '{
        {64'h1234_5678_9ABC_DEF0, 64'h429D_E8B8_5A8D_EE77},
        {64'h0000_0000_0000_003F, 64'h0000_0000_0000_00FF},
        {64'h0000_0000_0000_003F, 64'h0000_0000_0000_00FF},
        {8{16'hFF80}},
        {4{32'h1234_5604}},
        {16{8'hFE}}
    };
    localparam logic [1:0] T_SZ  [N_VEC] = '{2'd0, 2'd3, 2'd3, 2'd1, 2'd2, 2'd0};
    localparam logic       T_SG  [N_VEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic       T_Q   [N_VEC] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [127:0] T_EXP [N_VEC] = '{
        128'h0,
        {64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000},
        {64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000},
        {128{1'b1}},
        {4{32'hF0F0_F0F0}},
        {16{8'hE4}}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] value = '0;
    logic [127:0] amount = '0;
    logic [1:0]   lane_sz = '0;
    logic         sign_fill = 1'b0;
    logic         full_width = 1'b0;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vshl_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .value(value),
        .amount(amount), .lane_sz(lane_sz), .sign_fill(sign_fill),
        .full_width(full_width), .out_valid(out_valid), .result(result)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] model(input logic [127:0] val,
                                           input logic [127:0] sh,
                                           input int es, input bit sg, input bit q);
        int w;
        logic [63:0] msk;
        logic [127:0] r;
        w = 8 << es;
        msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [63:0] v;
            logic [63:0] o;
            longint sx;
            int a;
            int m;
            int s2;
            v = 64'(val >> (i * w)) & msk;
            a = int'($signed(sh[i*w +: 8]));
            if (a >= 0) begin
                o = (a >= w) ? 64'd0 : ((v << a) & msk);
            end else begin
                m = -a;
                if (sg) begin
                    sx = longint'(v << (64 - w)) >>> (64 - w);
                    s2 = (m >= w) ? w - 1 : m;
                    o = 64'(sx >>> s2) & msk;
                end else begin
                    o = (m >= w) ? 64'd0 : (v >> m);
                end
            end
            r = r | (128'(o) << (i * w));
        end
        if (!q) r[127:64] = '0;
        return r;
    endfunction

    task automatic apply(input logic [127:0] v, input logic [127:0] a,
                         input logic [1:0] s, input bit sg, input bit q);
        @(negedge clk);
        value = v; amount = a; lane_sz = s; sign_fill = sg; full_width = q;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [127:0] held;
        // R10: reset state
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid in reset", 128'(out_valid), 128'h0);
        check(result == '0, "R10 result in reset", result, 128'h0);
        rst_n = 1'b1;

        // table walk (R1 R2 R3 R4 R5 R6 R7)
        for (int k = 0; k < N_VEC; k++) begin
            apply(T_VAL[k], T_AMT[k], T_SZ[k], T_SG[k], T_Q[k]);
            check(out_valid == 1'b1, "R8 strobe after table entry", 128'(out_valid), 128'h1);
            check(result == T_EXP[k], $sformatf("R6 table entry %0d", k), result, T_EXP[k]);
        end

        // amount sweep per width and mode; R1 junk upper bytes, R3 R4 R5 saturation
        for (int es = 0; es < 4; es++) begin
            for (int sg = 0; sg < 2; sg++) begin
                int w;
                int amts [8];
                w = 8 << es;
                amts = '{0, w - 1, w, 127, -1, -(w - 1), -w, -128};
                for (int j = 0; j < 8; j++) begin
                    logic [127:0] v;
                    logic [127:0] a;
                    logic [127:0] e;
                    bit q;
                    for (int b = 0; b < 16; b++) begin
                        a[b*8 +: 8] = ((b % (w / 8)) == 0) ? 8'(amts[j]) : (8'h5A ^ 8'(b));
                    end
                    v = {32'hDEAD_BEEF ^ 32'(j), 32'h8123_4567, 32'h7F00_FF81,
                         32'hC0FF_EE11 + 32'(es * 16 + j)};
                    q = ((j % 3) != 0);
                    e = model(v, a, es, sg[0], q);
                    apply(v, a, 2'(es), sg[0], q);
                    check(result == e,
                          $sformatf("R5 R4 R3 R1 size=%0d signed=%0d amt=%0d", w, sg, amts[j]),
                          result, e);
                end
            end
        end

        // R7: half width zeros upper bits
        apply({128{1'b1}}, '0, 2'd0, 1'b0, 1'b0);
        check(result == {64'h0, {64{1'b1}}}, "R7 upper half cleared", result,
              {64'h0, {64{1'b1}}});

        // R8: strobe drops one cycle after in_valid drops
        @(negedge clk);
        check(out_valid == 1'b0, "R8 strobe clears", 128'(out_valid), 128'h0);

        // R9: inputs change with in_valid low, result holds
        held = result;
        @(negedge clk);
        value = {128{1'b1}}; amount = '0; full_width = 1'b1;
        repeat (2) @(negedge clk);
        check(result == held, "R9 result held while idle", result, held);

        // R2: plain left and right moves in 16-bit lanes
        apply({8{16'h0011}}, {8{16'h0003}}, 2'd1, 1'b0, 1'b1);
        check(result == {8{16'h0088}}, "R2 left by 3", result, {8{16'h0088}});
        apply({8{16'h8800}}, {8{16'h00FD}}, 2'd1, 1'b0, 1'b1);
        check(result == {8{16'h1100}}, "R2 logical right by 3", result, {8{16'h1100}});

        // R10: reset clears a loaded result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result == '0, "R10 result cleared by reset", result, 128'h0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule